// File: doc/BRIEF.md
# Ethernet Port Status Indicator and Shared GPIO Pins

This block drives three active-low status lamps for a 10/100 Ethernet port: a speed lamp, a link/activity lamp and a full-duplex lamp. Each lamp shares a pad with a general-purpose I/O bit. Software picks one of four drives for each pad: input, push-pull output, open-drain output, or lamp output. In lamp mode the pad is only ever pulled low or released.

The link/activity lamp is steady on while the link is up. A transmit or receive strobe makes it blink. The lamp goes off for one blink interval and then stays on for at least one more interval. Strobes that arrive during either interval are remembered and start the next off interval. Losing the link cancels everything.

The blink interval is `BLINK_CYC = (CLK_HZ/1000)*BLINK_MS` clock cycles. The block also captures a speed-select strap input once, at the first clock after reset is released. Pads in input mode are read back through a two-flop synchronizer.

Top module: `eth_led_gpio`

The link/activity sequencer has four states:

| State | Lamp | Meaning |
|-------|------|---------|
| NOLINK | off | No link. |
| IDLE | on | Link up, no activity. |
| OFF | off | Blink off interval. |
| HOLD | on | Minimum on interval. |

Its transitions are listed below. Any state goes to NOLINK when `link_up` is low; this overrides every other transition, clears the pending flag and stops the interval counter.

| From | To | Condition |
|------|----|-----------|
| NOLINK | IDLE | Link is up. |
| IDLE | OFF | Activity or pending. |
| OFF | HOLD | After `BLINK_CYC` cycles; activity seen during OFF sets pending. |
| HOLD | OFF | After `BLINK_CYC` cycles, when activity is present or pending. |
| HOLD | IDLE | After `BLINK_CYC` cycles, otherwise. |

## Requirements
- R1: Pad i uses mode field `pin_mode[2i+1:2i]` when `led_en[i]` is 0. 00 and 11 mean input (`pad_oe`=0, `pad_o`=0). 01 means push-pull (`pad_oe`=1, `pad_o`=`pin_out_data[i]`). 10 means open-drain (`pad_o`=0, `pad_oe`=NOT `pin_out_data[i]`).
- R2: With `led_en[i]`=1, pad i shows lamp i regardless of its mode field. Lamp 0 is speed, lamp 1 is link/activity and lamp 2 is duplex. The pad sets `pad_o`=0 and `pad_oe`=1 exactly when the lamp level is low, so it never drives high.
- R3: The speed lamp level is low when `speed_100`, `aneg_busy` or NOT `link_up` is true, and high otherwise.
- R4: The duplex lamp level is low exactly when `link_up` and `full_duplex` are both high.
- R5: The link/activity level goes high in the same cycle `link_up` falls. It goes low one clock edge after `link_up` is seen high, provided there is no activity.
- R6: Activity means `tx_act` or `rx_act` is high at a rising edge in IDLE. From that edge the link/activity level is high for exactly `BLINK_CYC` cycles, then low for at least `BLINK_CYC` cycles.
- R7: Activity seen during OFF or HOLD is kept pending. When HOLD ends with activity pending, a new OFF interval starts at once, so continuous activity gives a period of 2*`BLINK_CYC`.
- R8: Link loss clears the pending flag. After the link returns, the lamp stays on until new activity arrives.
- R9: `strap_speed` takes the value of `strap_speed_in` at the first rising edge after `rst_n` goes high. Later changes of the input have no effect. It is 0 during reset.
- R10: `pin_rd[i]` follows the pad's own level.
  - In input mode it shows `pad_in[i]` delayed by two rising edges.
  - In lamp mode it shows the lamp level.
  - Otherwise it shows `pin_out_data[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link valid |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Full-duplex link |
| aneg_busy | input | 1 | Auto-negotiation in progress |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| strap_speed_in | input | 1 | Speed-select strap pin |
| strap_speed | output | 1 | Latched strap value |
| pin_mode | input | 6 | Two mode bits per pad |
| pin_out_data | input | 3 | Output data per pad |
| led_en | input | 3 | Lamp mode per pad |
| pad_in | input | 3 | Pad input levels |
| pin_rd | output | 3 | Readback per pad |
| pad_o | output | 3 | Pad output value |
| pad_oe | output | 3 | Pad output enable |

## Verification
The assertions assume that `link_up` and the activity strobes are synchronous to `clk`, and that `pin_mode`, `led_en` and `pin_out_data` are only changed between edges. The bench drives every input on the falling edge, so each value is stable across the sampling edge. The activity strobes are held low during the random phase, so the sequencer stays in IDLE or NOLINK there. Every blink is driven from directed sequences with known edge counts.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;
    localparam int unsigned NPIN = 3;

    typedef enum logic [1:0] {
        PM_INPUT     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_OPENDRAIN = 2'b10,
        PM_RSVD      = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        ST_NOLINK = 2'b00,
        ST_IDLE   = 2'b01,
        ST_OFF    = 2'b10,
        ST_HOLD   = 2'b11
    } blink_st_e;
endpackage

// File: rtl/eth_led_sync.sv
module eth_led_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/eth_led_blink.sv
module eth_led_blink
    import eth_led_pkg::*;
#(
    parameter int unsigned BLINK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic act,
    output logic led_off
);
    localparam int unsigned CW = (BLINK_CYC < 2) ? 1 : $clog2(BLINK_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_CYC - 1);

    blink_st_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;
    logic          cnt_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NOLINK;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign cnt_last = (cnt_q == CNT_LAST);

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        if (!link_up) begin
            state_d = ST_NOLINK;
            cnt_d   = '0;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_NOLINK: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
                ST_IDLE: begin
                    if (act || pend_q) begin
                        state_d = ST_OFF;
                        cnt_d   = '0;
                        pend_d  = 1'b0;
                    end
                end
                ST_OFF: begin
                    if (act) pend_d = 1'b1;
                    if (cnt_last) begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt_last) begin
                        cnt_d = '0;
                        if (act || pend_q) begin
                            state_d = ST_OFF;
                            pend_d  = 1'b0;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                        if (act) pend_d = 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        led_off = !link_up || (state_q == ST_NOLINK) || (state_q == ST_OFF);
    end

    a_r5_link_drop_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> state_q == ST_NOLINK);
    a_r6_hold_follows_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_HOLD) |-> $past(state_q) == ST_OFF);
    a_r6_interval_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF || state_q == ST_HOLD) |-> cnt_q <= CNT_LAST);
    a_r7_pending_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cnt_last && link_up && pend_q) |=> state_q == ST_OFF);
    a_r8_no_pend_without_link: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_NOLINK |-> !pend_q);
endmodule

// File: rtl/eth_led_pin.sv
module eth_led_pin
    import eth_led_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       led_en,
    input  logic       out_data,
    input  logic       led_level,
    input  logic       sync_in,
    output logic       pad_o,
    output logic       pad_oe,
    output logic       rd
);
    always_comb begin
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        rd     = out_data;
        if (led_en) begin
            pad_oe = !led_level;
            rd     = led_level;
        end else begin
            unique case (pin_mode_e'(mode))
                PM_PUSHPULL: begin
                    pad_o  = out_data;
                    pad_oe = 1'b1;
                end
                PM_OPENDRAIN: begin
                    pad_oe = !out_data;
                end
                PM_INPUT, PM_RSVD: begin
                    rd = sync_in;
                end
            endcase
        end
    end

    always_comb begin
        a_r2_lamp_never_high: assert (!(led_en && pad_oe && pad_o));
        a_r1_input_released: assert (!(!led_en && !mode[0] && !mode[1] && pad_oe));
    end
endmodule

// File: rtl/eth_led_gpio.sv
module eth_led_gpio
    import eth_led_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter int unsigned BLINK_MS = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_up,
    input  logic                speed_100,
    input  logic                full_duplex,
    input  logic                aneg_busy,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                strap_speed_in,
    output logic                strap_speed,
    input  logic [2*NPIN-1:0]   pin_mode,
    input  logic [NPIN-1:0]     pin_out_data,
    input  logic [NPIN-1:0]     led_en,
    input  logic [NPIN-1:0]     pad_in,
    output logic [NPIN-1:0]     pin_rd,
    output logic [NPIN-1:0]     pad_o,
    output logic [NPIN-1:0]     pad_oe
);
    localparam int unsigned BLINK_CYC = (CLK_HZ / 1000) * BLINK_MS;

    logic            act_off;
    logic [NPIN-1:0] lamp_lvl;
    logic [NPIN-1:0] in_sync;
    logic            strap_q;
    logic            strap_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q      <= 1'b0;
            strap_done_q <= 1'b0;
        end else if (!strap_done_q) begin
            strap_q      <= strap_speed_in;
            strap_done_q <= 1'b1;
        end
    end
    assign strap_speed = strap_q;

    eth_led_blink #(.BLINK_CYC(BLINK_CYC)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .act     (tx_act | rx_act),
        .led_off (act_off)
    );

    assign lamp_lvl[0] = !(speed_100 || aneg_busy || !link_up);
    assign lamp_lvl[1] = act_off;
    assign lamp_lvl[2] = !(link_up && full_duplex);

    eth_led_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        eth_led_pin u_pin (
            .mode      (pin_mode[2*gi +: 2]),
            .led_en    (led_en[gi]),
            .out_data  (pin_out_data[gi]),
            .led_level (lamp_lvl[gi]),
            .sync_in   (in_sync[gi]),
            .pad_o     (pad_o[gi]),
            .pad_oe    (pad_oe[gi]),
            .rd        (pin_rd[gi])
        );
    end

    a_r9_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done_q && $past(strap_done_q)) |-> $stable(strap_q));
endmodule

// File: tb/eth_led_gpio_bench.sv
module eth_led_gpio_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8; // CLK_HZ=1000, BLINK_MS=8

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_up = 0, speed_100 = 0, full_duplex = 0, aneg_busy = 0;
    logic tx_act = 0, rx_act = 0, strap_speed_in = 0;
    logic strap_speed;
    logic [5:0] pin_mode = '0;
    logic [2:0] pin_out_data = '0, led_en = '0, pad_in = '0;
    logic [2:0] pin_rd, pad_o, pad_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_led_gpio #(.CLK_HZ(1000), .BLINK_MS(8)) u_eth_led_gpio (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
        .full_duplex(full_duplex), .aneg_busy(aneg_busy), .tx_act(tx_act),
        .rx_act(rx_act), .strap_speed_in(strap_speed_in), .strap_speed(strap_speed),
        .pin_mode(pin_mode), .pin_out_data(pin_out_data), .led_en(led_en),
        .pad_in(pad_in), .pin_rd(pin_rd), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic lamp_level(input int i, input logic lk, input logic sp,
                                        input logic dp, input logic an);
        if (i == 0) return !(sp || an || !lk);
        if (i == 1) return !lk;
        return !(lk && dp);
    endfunction

    function automatic logic [2:0] exp_pad(input logic [1:0] md, input logic le,
                                           input logic dat, input logic lvl, input logic pin);
        // returns {rd, oe, o}
        if (le) return {lvl, !lvl, 1'b0};
        if (md == 2'b01) return {dat, 1'b1, dat};
        if (md == 2'b10) return {dat, !dat, 1'b0};
        return {pin, 1'b0, 1'b0};
    endfunction

    task automatic lamp1_run(input logic exp_off, input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            chk(pad_oe[1] == !exp_off, tag, pad_oe[1], !exp_off);
            step(1);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        strap_speed_in = 1;
        step(3);
        // reset state
        chk(strap_speed == 0, "R9 reset", strap_speed, 0);
        chk(pad_oe == 3'b000, "R1 reset oe", pad_oe, 0);
        @(negedge clk); rst_n = 1;
        step(1);
        chk(strap_speed == 1, "R9 capture", strap_speed, 1);
        strap_speed_in = 0;
        step(3);
        chk(strap_speed == 1, "R9 hold", strap_speed, 1);

        // R5 link up/down in lamp mode
        led_en = 3'b111;
        @(negedge clk); link_up = 1; #1;
        chk(pad_oe[1] == 0, "R5 off before edge", pad_oe[1], 0);
        step(1);
        chk(pad_oe[1] == 1, "R5 on after edge", pad_oe[1], 1);
        @(negedge clk); link_up = 0; #1;
        chk(pad_oe[1] == 0, "R5 drop same cycle", pad_oe[1], 0);
        @(negedge clk); link_up = 1;
        step(3);

        // R6 single blink
        @(negedge clk); tx_act = 1;
        @(negedge clk); tx_act = 0; #1;
        lamp1_run(1, N, "R6 off interval");
        lamp1_run(0, N + 3, "R6 on interval");

        // R7 pending activity during off
        @(negedge clk); rx_act = 1;
        @(negedge clk); rx_act = 0;
        step(2);
        @(negedge clk); tx_act = 1;
        @(negedge clk); tx_act = 0; #1;
        lamp1_run(1, N - 4, "R7 first off");
        lamp1_run(0, N, "R7 hold");
        lamp1_run(1, N, "R7 pending off");
        lamp1_run(0, N + 2, "R7 settle");

        // R7 continuous activity
        @(negedge clk); tx_act = 1;
        @(negedge clk); #1;
        for (int c = 0; c < 3; c++) begin
            lamp1_run(1, N, "R7 steady off");
            lamp1_run(0, N, "R7 steady on");
        end
        @(negedge clk); tx_act = 0;
        step(3 * N);

        // R8 link loss clears pending
        @(negedge clk); tx_act = 1;
        @(negedge clk); tx_act = 0;
        step(2);
        @(negedge clk); rx_act = 1;
        @(negedge clk); rx_act = 0; link_up = 0;
        @(negedge clk); link_up = 1;
        step(2);
        lamp1_run(0, 3 * N, "R8 no stale blink");

        // R10 synchronizer delay
        led_en = 3'b000; pin_mode = 6'b00_00_00;
        @(negedge clk); pad_in = 3'b101;
        @(negedge clk); #1;
        chk(pin_rd == 3'b000, "R10 one edge", pin_rd, 0);
        step(1);
        chk(pin_rd == 3'b101, "R10 two edges", pin_rd, 5);

        // random configuration and status, no activity
        for (int it = 0; it < 200; it++) begin
            @(negedge clk);
            pin_mode = 6'($urandom); pin_out_data = 3'($urandom);
            led_en = 3'($urandom); pad_in = 3'($urandom);
            link_up = 1'($urandom); speed_100 = 1'($urandom);
            full_duplex = 1'($urandom); aneg_busy = 1'($urandom);
            step(3);
            for (int i = 0; i < 3; i++) begin
                logic lvl;
                logic [2:0] e;
                lvl = lamp_level(i, link_up, speed_100, full_duplex, aneg_busy);
                e = exp_pad(pin_mode[2*i +: 2], led_en[i], pin_out_data[i], lvl, pad_in[i]);
                if (led_en[i] && i == 0) chk(pad_oe[i] == e[1], "R3 speed lamp", pad_oe[i], e[1]);
                else if (led_en[i] && i == 2) chk(pad_oe[i] == e[1], "R4 duplex lamp", pad_oe[i], e[1]);
                else if (led_en[i]) chk(pad_oe[i] == e[1], "R2 lamp oe", pad_oe[i], e[1]);
                else chk(pad_oe[i] == e[1], "R1 mode oe", pad_oe[i], e[1]);
                chk(pad_o[i] == e[0], "R1 R2 pad value", pad_o[i], e[0]);
                chk(pin_rd[i] == e[2], "R10 readback", pin_rd[i], e[2]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule